// File: doc/BRIEF.md
# Multi-channel memory error down-counter

This block keeps a separate error down-counter for each of four memory channels. The memory side reports errors through a per-channel strobe. Each strobe stands for one errored 16-byte data chunk. While a channel is armed, each strobe takes one off that channel's count. When the count runs out, the channel disarms itself. If its interrupt enable is set, it also raises a one-cycle interrupt request. Software arms a channel by writing a starting count together with the armed and enable flags. It can read the state back at any time.

Each channel appears as a 64-bit register on a simple register bus. The bus has a valid, write, address and 64-bit data interface. The channel registers sit at byte offset 0x298 within a channel window of 4096 bytes. The channel number comes from the address bits just above that window. Reads return data one cycle after the request. Addresses that map to no register read as zero, and writes to them are dropped.

Top module: `err_cnt_bank`

## Requirements
- R1: After reset, every channel reads 0x0 and no interrupt request is asserted.
- R2: Register layout: bits 15:0 hold the count, bit 16 is the armed flag and bit 17 is the interrupt enable. All three are read/write. Bits 63:18 always read zero, and writes to them are ignored.
- R3: A strobe on a channel whose armed flag is 1 and whose count is 2 or more lowers the count by one. The flags are unchanged.
- R4: A strobe on a channel whose armed flag is 0 has no effect on that channel's register.
- R5: A strobe that takes the count from 1 to 0 on a channel with the armed flag and the enable both set does two things. It raises that channel's interrupt request for exactly one cycle, in the cycle after the strobe. It also clears the armed flag, while the enable keeps its value.
- R6: A 1-to-0 step with the enable clear clears the armed flag and raises no interrupt request.
- R7: A strobe on an armed channel whose count is already 0 leaves the count at 0. It clears the armed flag and raises no interrupt request.
- R8: A software write that sets the count to 0 raises no interrupt request.
- R9: A register write and a strobe to the same channel in the same cycle store the written value. That cycle's decrement is dropped.
- R10: Channel n decodes at byte address 0x298 + n*0x1000 (n = 0..3). An access to one channel leaves the others unchanged.
- R11: A read of any other address returns zero, and a write to one changes no channel.
- R12: Read data and its valid flag appear in the cycle after the read request, and the valid flag lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvld | output | 1 | Read data valid, one cycle after a read |
| err_strobe | input | 4 | One errored chunk per channel per cycle |
| irq_req | output | 4 | Per-channel interrupt request pulse |

## Verification
Every result of this block is one register stage away from its cause. A write or strobe applied before a rising edge shows up in the channel state after that edge. The interrupt pulse is high only in the cycle after the decrementing strobe. Read data and its valid flag follow the request by one edge.

The bench drives inputs at falling edges and samples outputs at the next falling edge, which is the cycle where each result is due. It then checks the cycle after that to confirm the interrupt and read-valid pulses have dropped.

// File: rtl/err_cnt_pkg.sv
package err_cnt_pkg;
  localparam int CNT_W   = 16;
  localparam int ARM_BIT = 16;
  localparam int ENB_BIT = 17;
  localparam int FLD_W   = ENB_BIT + 1;
  localparam int REG_W   = 64;

  typedef struct packed {
    logic             enb;
    logic             arm;
    logic [CNT_W-1:0] cnt;
  } chan_state_t;
endpackage

// File: rtl/err_cnt_decode.sv
module err_cnt_decode #(
  parameter int          ADDR_W    = 16,
  parameter int          NUM_CH    = 4,
  parameter int          CH_STRIDE = 4096,
  parameter logic [11:0] REG_OFS   = 12'h298
) (
  input  logic [ADDR_W-1:0]         addr,
  output logic                      hit,
  output logic [$clog2(NUM_CH)-1:0] ch
);
  localparam int CH_SHIFT = $clog2(CH_STRIDE);
  localparam int CH_BITS  = $clog2(NUM_CH);

  logic [ADDR_W-1:0] upper;
  logic [ADDR_W-1:0] low;

  always_comb begin
    upper = addr >> (CH_SHIFT + CH_BITS);
    low   = addr & ADDR_W'(CH_STRIDE - 1);
    ch    = addr[CH_SHIFT +: CH_BITS];
    hit   = (upper == '0) && (low == ADDR_W'(REG_OFS));
  end
endmodule

// File: rtl/err_cnt_chan.sv
module err_cnt_chan
  import err_cnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [FLD_W-1:0] wr_fld,
  input  logic             strobe,
  output chan_state_t      st,
  output logic             irq
);
  chan_state_t st_q;
  logic        irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_en) begin
        st_q.cnt <= wr_fld[CNT_W-1:0];
        st_q.arm <= wr_fld[ARM_BIT];
        st_q.enb <= wr_fld[ENB_BIT];
      end else if (strobe && st_q.arm) begin
        if (st_q.cnt == CNT_W'(1)) begin
          st_q.cnt <= '0;
          st_q.arm <= 1'b0;
          irq_q    <= st_q.enb;
        end else if (st_q.cnt == '0) begin
          st_q.arm <= 1'b0;
        end else begin
          st_q.cnt <= st_q.cnt - CNT_W'(1);
        end
      end
    end
  end

  assign st  = st_q;
  assign irq = irq_q;
endmodule

// File: rtl/err_cnt_bank.sv
module err_cnt_bank
  import err_cnt_pkg::*;
#(
  parameter int          NUM_CH    = 4,
  parameter int          ADDR_W    = 16,
  parameter int          CH_STRIDE = 4096,
  parameter logic [11:0] REG_OFS   = 12'h298
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_vld,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              bus_rvld,
  input  logic [NUM_CH-1:0] err_strobe,
  output logic [NUM_CH-1:0] irq_req
);
  localparam int CH_BITS = $clog2(NUM_CH);

  logic                          dec_hit;
  logic [CH_BITS-1:0]            dec_ch;
  logic [NUM_CH-1:0]             wr_sel;
  chan_state_t                   ch_st [NUM_CH];
  logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
  logic [NUM_CH-1:0]             ch_arm;
  logic [NUM_CH-1:0]             ch_enb;
  logic [REG_W-1:0]              rd_mux;
  logic                          unused_wdata_hi;

  assign unused_wdata_hi = &{1'b0, bus_wdata[REG_W-1:FLD_W]};

  err_cnt_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_STRIDE(CH_STRIDE), .REG_OFS(REG_OFS)
  ) i_dec (
    .addr(bus_addr), .hit(dec_hit), .ch(dec_ch)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign wr_sel[g] = bus_vld && bus_wr && dec_hit && (dec_ch == CH_BITS'(g));

    err_cnt_chan i_chan (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (wr_sel[g]),
      .wr_fld (bus_wdata[FLD_W-1:0]),
      .strobe (err_strobe[g]),
      .st     (ch_st[g]),
      .irq    (irq_req[g])
    );

    assign ch_cnt[g] = ch_st[g].cnt;
    assign ch_arm[g] = ch_st[g].arm;
    assign ch_enb[g] = ch_st[g].enb;
  end

  always_comb begin
    rd_mux = '0;
    if (dec_hit) rd_mux = REG_W'(ch_st[dec_ch]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_rvld  <= 1'b0;
    end else begin
      bus_rvld  <= bus_vld && !bus_wr;
      bus_rdata <= (bus_vld && !bus_wr) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/err_cnt_bank_chk.sv
module err_cnt_bank_chk
  import err_cnt_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         bus_vld,
  input logic                         bus_wr,
  input logic [REG_W-1:0]             bus_rdata,
  input logic                         bus_rvld,
  input logic [NUM_CH-1:0]            err_strobe,
  input logic [NUM_CH-1:0]            irq_req,
  input logic [NUM_CH-1:0]            wr_sel,
  input logic [NUM_CH-1:0][CNT_W-1:0] ch_cnt,
  input logic [NUM_CH-1:0]            ch_arm,
  input logic [NUM_CH-1:0]            ch_enb
);
  p_rd_latency_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_vld && !bus_wr) |=> bus_rvld);

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rvld |-> (bus_rdata[REG_W-1:FLD_W] == '0));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
      irq_req[g] |-> $past(err_strobe[g] && !wr_sel[g] && ch_arm[g] &&
                           ch_enb[g] && (ch_cnt[g] == CNT_W'(1))));

    p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
      irq_req[g] |=> !irq_req[g]);

    p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
      (err_strobe[g] && !wr_sel[g] && ch_arm[g] && (ch_cnt[g] == CNT_W'(1)))
        |=> (!ch_arm[g] && (ch_cnt[g] == '0)));

    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
      (err_strobe[g] && !wr_sel[g] && ch_arm[g] && (ch_cnt[g] == '0))
        |=> (!ch_arm[g] && (ch_cnt[g] == '0) && !irq_req[g]));

    p_idle_ignore_r4: assert property (@(posedge clk) disable iff (rst)
      (err_strobe[g] && !wr_sel[g] && !ch_arm[g])
        |=> ($stable(ch_cnt[g]) && !ch_arm[g] && $stable(ch_enb[g])));

    p_write_wins_r9: assert property (@(posedge clk) disable iff (rst)
      wr_sel[g] |=> !irq_req[g]);
  end
endmodule

bind err_cnt_bank err_cnt_bank_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .bus_rvld(bus_rvld), .err_strobe(err_strobe),
  .irq_req(irq_req), .wr_sel(wr_sel), .ch_cnt(ch_cnt),
  .ch_arm(ch_arm), .ch_enb(ch_enb)
);

// File: tb/test_err_cnt_bank.sv
`timescale 1ns/1ps
module test_err_cnt_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_vld = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_rvld;
  logic [3:0]  err_strobe = '0;
  logic [3:0]  irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  err_cnt_bank i_err_cnt_bank (
    .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvld(bus_rvld), .err_strobe(err_strobe), .irq_req(irq_req)
  );

  typedef struct packed {
    logic        is_wr;
    logic [15:0] addr;
    logic [63:0] data;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0298, 64'hFFFF_FFFF_FFFF_1234},
    '{1'b0, 16'h0298, 64'h0000_0000_0003_1234},
    '{1'b1, 16'h1298, 64'h0000_0000_0001_ABCD},
    '{1'b0, 16'h1298, 64'h0000_0000_0001_ABCD},
    '{1'b1, 16'h2298, 64'h0000_0000_0002_0042},
    '{1'b0, 16'h2298, 64'h0000_0000_0002_0042},
    '{1'b1, 16'h3298, 64'hFFFF_FFFF_FFFC_FFFF},
    '{1'b0, 16'h3298, 64'h0000_0000_0000_FFFF},
    '{1'b0, 16'h0298, 64'h0000_0000_0003_1234},
    '{1'b1, 16'h0290, 64'h0000_0000_0000_0007},
    '{1'b0, 16'h0298, 64'h0000_0000_0003_1234},
    '{1'b0, 16'h0290, 64'h0},
    '{1'b0, 16'h4298, 64'h0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [63:0] d,
                           input logic [3:0] strb);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; err_strobe = strb;
    @(negedge clk);
    bus_vld = 1'b0; bus_wr = 1'b0; err_strobe = '0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [63:0] d,
                          output logic v);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_vld = 1'b0;
    d = bus_rdata;
    v = bus_rvld;
  endtask

  task automatic pulse(input logic [3:0] strb);
    @(negedge clk);
    err_strobe = strb;
    @(negedge clk);
    err_strobe = '0;
  endtask

  task automatic expect_reg(input logic [15:0] a, input logic [63:0] exp,
                            input string tag);
    logic [63:0] d;
    logic v;
    bus_read(a, d, v);
    chk(v === 1'b1, "R12 rvld", {63'd0, v}, 64'd1);
    chk(d === exp, tag, d, exp);
  endtask

  initial begin
    logic [63:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    chk(irq_req === 4'b0, "R1 irq after reset", {60'd0, irq_req}, 64'd0);
    for (int c = 0; c < 4; c++) expect_reg(16'h0298 + 16'(c * 4096), 64'd0, "R1 reset value");

    bus_read(16'h1298, d, v);
    chk(v === 1'b1, "R12 rvld due", {63'd0, v}, 64'd1);
    @(negedge clk);
    chk(bus_rvld === 1'b0, "R12 rvld one cycle", {63'd0, bus_rvld}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_wr) bus_write(VECS[i].addr, VECS[i].data, 4'b0);
      else expect_reg(VECS[i].addr, VECS[i].data, "R2/R10/R11 table");
    end

    bus_write(16'h1298, 64'h3_0005, 4'b0);
    pulse(4'b0010);
    expect_reg(16'h1298, 64'h3_0004, "R3 decrement");
    pulse(4'b0010);
    pulse(4'b0010);
    expect_reg(16'h1298, 64'h3_0002, "R3 repeated decrement");
    expect_reg(16'h0298, 64'h3_1234, "R10 other channel untouched");

    bus_write(16'h2298, 64'h2_0007, 4'b0);
    pulse(4'b0100); pulse(4'b0100); pulse(4'b0100);
    expect_reg(16'h2298, 64'h2_0007, "R4 strobe while disarmed");

    bus_write(16'h1298, 64'h3_0001, 4'b0);
    pulse(4'b0010);
    chk(irq_req === 4'b0010, "R5 irq pulse", {60'd0, irq_req}, 64'h2);
    @(negedge clk);
    chk(irq_req === 4'b0000, "R5 irq one cycle", {60'd0, irq_req}, 64'h0);
    expect_reg(16'h1298, 64'h2_0000, "R5 armed flag cleared");

    bus_write(16'h3298, 64'h1_0001, 4'b0);
    pulse(4'b1000);
    chk(irq_req === 4'b0000, "R6 no irq without enable", {60'd0, irq_req}, 64'h0);
    expect_reg(16'h3298, 64'h0, "R6 disarmed at zero");

    bus_write(16'h0298, 64'h3_0000, 4'b0);
    chk(irq_req === 4'b0000, "R8 no irq on write of zero", {60'd0, irq_req}, 64'h0);
    @(negedge clk);
    chk(irq_req === 4'b0000, "R8 no irq later", {60'd0, irq_req}, 64'h0);
    pulse(4'b0001);
    chk(irq_req === 4'b0000, "R7 no irq at zero", {60'd0, irq_req}, 64'h0);
    expect_reg(16'h0298, 64'h2_0000, "R7 no wrap, disarmed");

    bus_write(16'h0298, 64'h3_0009, 4'b0001);
    expect_reg(16'h0298, 64'h3_0009, "R9 write wins over strobe");
    bus_write(16'h2298, 64'h3_0001, 4'b0100);
    chk(irq_req === 4'b0000, "R9 no irq on write cycle", {60'd0, irq_req}, 64'h0);
    expect_reg(16'h2298, 64'h3_0001, "R9 written value kept");

    bus_write(16'h1290, 64'h3_0001, 4'b0);
    expect_reg(16'h1298, 64'h2_0000, "R11 unmapped write ignored");

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule